// File: doc/BRIEF.md
# ARINC 429 Label-Indexed Receive Store

This block sits behind eight ARINC 429 line receivers that have already done bit timing and protocol checks. Each receiver hands over a 32-bit word, its channel number and a flag that marks a bad encoding. The block files every accepted word in a block of receive memory that belongs to the word's channel and label. The label is the position of the block, so it is not kept. The first byte of the block holds a new-data status byte instead. A per-block trigger table decides whether storing a word should interrupt the host. A host reads the store one byte at a time and sets up the block through a small register write port.

Interrupts are kept per channel. A pending bit is set for the channel, the label that caused it is latched, and a mask register gates the single interrupt output. A two-state machine holds the global receive enable. In `ST_OFF`, incoming words are consumed and dropped. In `ST_ON`, they are stored. A control write with bit 0 set takes `ST_OFF` to `ST_ON`. A control write with bit 0 clear takes `ST_ON` back to `ST_OFF`. Reset enters `ST_OFF`.

Top module: `rx_label_store`

## Requirements
- R1: In state `ST_OFF`, words are dropped: no memory write, no status change and no interrupt. Writing register 0x000 with bit 0 set enters `ST_ON`, and writing it with bit 0 clear returns to `ST_OFF`.
- R2: A word presented with `in_bad` high causes no memory write and no pending bit.
- R3: A word of channel c and label L (bits 7:0 of the word) lands in the 4-byte block at byte address c*1024 + L*4. Channel 7 label 0xFF lands at 0x1FFC.
- R4: Byte offsets 1, 2 and 3 of a block read back word bits 15:8, 23:16 and 31:24.
- R5: After a word is stored, offset 0 of its block reads 0x3F.
- R6: A host read of offset 0 returns the status byte and then clears that block's status to 0x00. If a word is stored into the same block in the same cycle, the read returns the old value and the status stays at 0x3F.
- R7: If the trigger-table bit of the block is 1, storing the word sets bit c of `pend_o` and loads L into byte c of `irq_label_o`.
- R8: `irq_o` is high exactly when some bit is set in `pend_o` and the matching bit of the mask register (0x001, where 1 means masked) is 0.
- R9: Writing register 0x002 clears every `pend_o` bit written as 1. A trigger on the same channel in the same cycle keeps the bit set and loads the new label.
- R10: Writing register 0x100+n with byte v sets the trigger bits of channel n[7:5], labels {n[4:0],j}, to v[j]. A word stored in a block whose trigger bit is 0 sets no pending bit.
- R11: Reset gives state `ST_OFF`, every status byte 0x00, `pend_o` 0, `irq_label_o` 0, mask 0xFF and every trigger bit 0.
- R12: Bits 7:6 of every status byte always read 0.
- R13: `rd_data` shows the byte at `rd_addr` one clock after `rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receiver word present |
| in_ready | output | 1 | Word accepted this cycle (always high) |
| in_chan | input | 3 | Receiving channel number |
| in_word | input | 32 | Received word, label in bits 7:0 |
| in_bad | input | 1 | Word failed encoding checks |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 9 | Host register address |
| reg_wdata | input | 8 | Host register write data |
| rd_en | input | 1 | Host byte read strobe |
| rd_addr | input | 13 | Host byte read address |
| rd_data | output | 8 | Read byte, one cycle after strobe |
| pend_o | output | 8 | Per-channel pending interrupts |
| irq_label_o | output | 64 | Triggering label per channel, byte c for channel c |
| irq_o | output | 1 | Host interrupt |

## Verification
A stuck enable state shows up on the first word after the control write, as a missing or unexpected 0x3F status byte on the next read. A wrong block index puts data at a neighbouring address, and the wrong bytes appear one clock after the read strobe. A status flag that fails to clear, or that is lost to a read in the same cycle, shows on the next status read of that block. Pending, label and mask mistakes show on `pend_o`, `irq_label_o` and `irq_o` in the cycle after the causing edge.

// File: rtl/rx_store_pkg.sv
package rx_store_pkg;
    localparam int NCH      = 8;
    localparam int CH_W     = $clog2(NCH);
    localparam int LBL_W    = 8;
    localparam int IDX_W    = CH_W + LBL_W;
    localparam int NBLK     = 1 << IDX_W;
    localparam int BADDR_W  = IDX_W + 2;
    localparam int RADDR_W  = 9;

    typedef enum logic {ST_OFF = 1'b0, ST_ON = 1'b1} rx_state_t;

    localparam logic [RADDR_W-1:0] REG_CTRL = 9'h000;
    localparam logic [RADDR_W-1:0] REG_MASK = 9'h001;
    localparam logic [RADDR_W-1:0] REG_PCLR = 9'h002;
endpackage

// File: rtl/rx_block_mem.sv
module rx_block_mem
    import rx_store_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [23:0]        wr_bytes,
    input  logic               rd_en,
    input  logic [BADDR_W-1:0] rd_addr,
    output logic [7:0]         rd_data
);
    logic [NBLK-1:0]  newf;
    logic [23:0]      dat [NBLK];
    logic [IDX_W-1:0] rd_idx;
    logic             stat_rd;

    assign rd_idx  = rd_addr[BADDR_W-1:2];
    assign stat_rd = rd_en && (rd_addr[1:0] == 2'd0);

    // one flag bit per block stands for all six status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            newf <= '0;
        end else begin
            if (stat_rd) newf[rd_idx] <= 1'b0;
            if (wr_en)   newf[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) dat[wr_idx] <= wr_bytes;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (rd_addr[1:0])
                2'd0: rd_data <= {2'b00, {6{newf[rd_idx]}}};
                2'd1: rd_data <= dat[rd_idx][7:0];
                2'd2: rd_data <= dat[rd_idx][15:8];
                2'd3: rd_data <= dat[rd_idx][23:16];
            endcase
        end
    end
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
    import rx_store_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic [CH_W-1:0]      acc_chan,
    input  logic [LBL_W-1:0]     acc_lbl,
    input  logic                 lut_we,
    input  logic [IDX_W-4:0]     lut_byte,
    input  logic [7:0]           lut_wdata,
    input  logic                 mask_we,
    input  logic                 clr_we,
    input  logic [7:0]           wdata,
    output logic [NCH-1:0]       pend,
    output logic [NCH*LBL_W-1:0] labels,
    output logic [NCH-1:0]       mask,
    output logic                 irq
);
    logic [NBLK-1:0] lut;
    logic            hit;
    logic [NCH-1:0]  set_v;
    logic [NCH-1:0]  clr_v;

    assign hit   = acc && lut[{acc_chan, acc_lbl}];
    assign set_v = hit ? (NCH'(1) << acc_chan) : '0;
    assign clr_v = clr_we ? wdata[NCH-1:0] : '0;
    assign irq   = |(pend & ~mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lut <= '0;
        end else if (lut_we) begin
            for (int j = 0; j < 8; j++) lut[{lut_byte, 3'(j)}] <= lut_wdata[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            mask <= '1;
        end else begin
            pend <= (pend & ~clr_v) | set_v;
            if (mask_we) mask <= wdata[NCH-1:0];
        end
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_lbl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) labels[c*LBL_W +: LBL_W] <= '0;
                else if (set_v[c]) labels[c*LBL_W +: LBL_W] <= acc_lbl;
            end
        end
    endgenerate
endmodule

// File: rtl/rx_label_store.sv
module rx_label_store
    import rx_store_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [CH_W-1:0]      in_chan,
    input  logic [31:0]          in_word,
    input  logic                 in_bad,
    input  logic                 reg_we,
    input  logic [RADDR_W-1:0]   reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic                 rd_en,
    input  logic [BADDR_W-1:0]   rd_addr,
    output logic [7:0]           rd_data,
    output logic [NCH-1:0]       pend_o,
    output logic [NCH*LBL_W-1:0] irq_label_o,
    output logic                 irq_o
);
    rx_state_t state, state_nx;
    logic      rx_on, acc, ctrl_we;
    logic [NCH-1:0] mask_q;

    assign ctrl_we = reg_we && (reg_addr == REG_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (ctrl_we &&  reg_wdata[0]) state_nx = ST_ON;
            ST_ON:  if (ctrl_we && !reg_wdata[0]) state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        in_ready = 1'b1;
        rx_on    = 1'b0;
        unique case (state)
            ST_OFF: rx_on = 1'b0;
            ST_ON:  rx_on = 1'b1;
        endcase
    end

    assign acc = in_valid && in_ready && rx_on && !in_bad;

    rx_block_mem u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc),
        .wr_idx   ({in_chan, in_word[7:0]}),
        .wr_bytes (in_word[31:8]),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    rx_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .acc_chan  (in_chan),
        .acc_lbl   (in_word[7:0]),
        .lut_we    (reg_we && reg_addr[8]),
        .lut_byte  (reg_addr[7:0]),
        .lut_wdata (reg_wdata),
        .mask_we   (reg_we && (reg_addr == REG_MASK)),
        .clr_we    (reg_we && (reg_addr == REG_PCLR)),
        .wdata     (reg_wdata),
        .pend      (pend_o),
        .labels    (irq_label_o),
        .mask      (mask_q),
        .irq       (irq_o)
    );
endmodule

// File: rtl/rx_label_store_chk.sv
module rx_label_store_chk
    import rx_store_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_on,
    input logic                 in_valid,
    input logic                 in_bad,
    input logic                 reg_we,
    input logic                 rd_en,
    input logic [BADDR_W-1:0]   rd_addr,
    input logic [7:0]           rd_data,
    input logic [NCH-1:0]       pend_o,
    input logic [NCH*LBL_W-1:0] irq_label_o,
    input logic                 irq_o
);
    AST_OFF_NO_IRQ_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_on && !reg_we) |=> ($stable(pend_o) && $stable(irq_label_o))); // R1
    AST_BAD_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bad && !reg_we) |=> $stable(pend_o)); // R2
    AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & ~$past(pend_o)) != '0) |-> $past(in_valid && !in_bad && rx_on)); // R7
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_o != '0)); // R8
    AST_STATUS_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (rd_addr[1:0] == 2'd0)) |-> (rd_data[7:6] == 2'b00)); // R12
endmodule

bind rx_label_store rx_label_store_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .in_valid(in_valid), .in_bad(in_bad),
    .reg_we(reg_we), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pend_o(pend_o), .irq_label_o(irq_label_o), .irq_o(irq_o)
);

// File: tb/tb_rx_label_store.sv
module tb_rx_label_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_bad = 1'b0;
    logic        in_ready;
    logic [2:0]  in_chan = '0;
    logic [31:0] in_word = '0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        rd_en = 1'b0;
    logic [12:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  pend_o;
    logic [63:0] irq_label_o;
    logic        irq_o;

    int checks = 0, failures = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    rx_label_store dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read data one clock after the strobe
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) chk(tag_q.pop_front(), {56'd0, rd_data}, {56'd0, exp_q.pop_front()});
    end

    task automatic regw(input logic [8:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic send(input logic [2:0] ch, input logic [31:0] w, input logic bad);
        in_valid = 1'b1; in_chan = ch; in_word = w; in_bad = bad;
        @(negedge clk);
        in_valid = 1'b0; in_bad = 1'b0;
    endtask

    // driver: issues a read and pushes the expected byte
    task automatic hread(input logic [12:0] a, input logic [7:0] e, input string tag);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                chk("R11 pend", {56'd0, pend_o}, 64'd0);
                chk("R11 labels", irq_label_o, 64'd0);
                chk("R11 irq", {63'd0, irq_o}, 64'd0);
                hread(13'h0C80, 8'h00, "R11 status");
                regw(9'h120, 8'h60);          // R10 ch1 labels 5,6
                regw(9'h140, 8'h80);          // R10 ch2 label 7
                regw(9'h1FF, 8'h80);          // ch7 label 0xFF
                send(3'd1, 32'hAABBCC05, 1'b0);
                hread(13'h0414, 8'h00, "R1 off status");
                chk("R1 off pend", {56'd0, pend_o}, 64'd0);
                regw(9'h000, 8'h01);
                send(3'd1, 32'hAABBCC05, 1'b0);
                chk("R7 pend", {56'd0, pend_o}, 64'h02);
                chk("R7 label", {56'd0, irq_label_o[15:8]}, 64'h05);
                chk("R8 masked", {63'd0, irq_o}, 64'd0);
                hread(13'h0414, 8'h3F, "R5 status");
                hread(13'h0415, 8'hCC, "R4 byte1");
                hread(13'h0416, 8'hBB, "R4 byte2");
                hread(13'h0417, 8'hAA, "R13 byte3");
                hread(13'h0414, 8'h00, "R6 cleared");
                regw(9'h001, 8'hFD);
                chk("R8 unmasked", {63'd0, irq_o}, 64'd1);
                send(3'd2, 32'h11223307, 1'b1);
                chk("R2 pend", {56'd0, pend_o}, 64'h02);
                hread(13'h081C, 8'h00, "R2 status");
                // R6 write wins over same-cycle status read
                in_valid = 1'b1; in_chan = 3'd1; in_word = 32'h01020305;
                rd_en = 1'b1; rd_addr = 13'h0414;
                exp_q.push_back(8'h00); tag_q.push_back("R6 old value");
                @(negedge clk);
                in_valid = 1'b0; rd_en = 1'b0;
                @(negedge clk);
                hread(13'h0414, 8'h3F, "R6 write wins");
                regw(9'h002, 8'h02);
                chk("R9 cleared", {56'd0, pend_o}, 64'd0);
                chk("R8 idle irq", {63'd0, irq_o}, 64'd0);
                // R9 same-cycle set beats clear
                reg_we = 1'b1; reg_addr = 9'h002; reg_wdata = 8'h02;
                in_valid = 1'b1; in_chan = 3'd1; in_word = 32'h77665506;
                @(negedge clk);
                reg_we = 1'b0; in_valid = 1'b0;
                chk("R9 set wins", {56'd0, pend_o}, 64'h02);
                chk("R9 label", {56'd0, irq_label_o[15:8]}, 64'h06);
                send(3'd4, 32'hDEADBE10, 1'b0);
                chk("R10 no trigger", {56'd0, pend_o}, 64'h02);
                hread(13'h1040, 8'h3F, "R10 stored");
                send(3'd7, 32'h123456FF, 1'b0);
                chk("R3 ch7 pend", {56'd0, pend_o}, 64'h82);
                chk("R3 ch7 label", {56'd0, irq_label_o[63:56]}, 64'hFF);
                hread(13'h1FFD, 8'h56, "R3 ch7 byte1");
                hread(13'h1FFC, 8'h3F, "R12 status");
                regw(9'h000, 8'h00);
                send(3'd3, 32'h99999920, 1'b0);
                hread(13'h0C80, 8'h00, "R1 back off");
                @(negedge clk);
                done = 1'b1;
            end
            begin
                repeat (20000) @(negedge clk);
                if (!done) begin
                    failures++;
                    $display("FAIL watchdog expired");
                end
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule